// File: doc/BRIEF.md
# Quadrature Position Decoder with Gated Index

This block turns the phase A, phase B and index signals of an incremental rotary or linear encoder into a position count of `CNT_W` bits. Its pin inputs are assumed to be synchronized and filtered upstream. Every edge of either phase moves the count by one step, which is four counts per encoder line. The sense of direction can be reversed by exchanging the two phases ahead of the decoder. The count is bounded by a programmable ceiling and wraps at both ends of the range.

A qualified index pulse can clear the count. An index pulse qualifies only when the two phases sit at one selected pair of levels. A mode bit picks between resetting only at the ceiling and also resetting on a qualified index. Wraps, index resets, direction reversals and an external watchdog event set sticky status bits. A mask decides which of these bits raise the single interrupt line.

The configuration fields are loaded from a flat set of inputs with a write strobe. The loaded values are frozen while counting is enabled. When counting is disabled, the count and the status are both frozen.

Top module: `qdec_index_top`

## Requirements
- R1: With swap off, the phase sequence {A,B} = 00, 10, 11, 01, 00 raises the count by one per step, and the reverse order lowers it by one. The new count is visible after the first rising clock edge at which the new pin levels are present.
- R2: With swap on, A and B exchange roles before decoding, so the sequence from R1 lowers the count and its reverse raises it.
- R3: A step in which A and B both change in the same cycle is illegal and leaves the count and the direction unchanged.
- R4: An up step taken while the count equals the ceiling makes the count 0 and sets status bit 2 (reset while counting up).
- R5: A down step taken while the count is 0 loads the ceiling and sets status bit 1 (reset while counting down).
- R6: With the reset-mode bit clear, a rising edge of the qualified index clears the count. The index qualifies when it is high and {A,B} equals the gate code: 0 = A low B low, 1 = A low B high, 2 = A high B low, 3 = A high B high. The reset sets status bit 2 if `dir` is 1, otherwise bit 1. This event takes precedence over a step in the same cycle. An index pulse at other levels is ignored.
- R7: With the reset-mode bit set, index pulses have no effect on the count or the status.
- R8: `dir` is 1 after the last valid up step and 0 after the last valid down step. A valid step whose direction differs from `dir` sets status bit 3.
- R9: A high `wdt_evt` while enabled sets status bit 0.
- R10: Status bits are sticky. A 1 in `irq_clr` clears the matching bit. A set and a clear of the same bit in the same cycle leave the bit set.
- R11: `irq` is the OR of the status bits whose `irq_mask` bit is 0. A mask bit of 1 suppresses that bit.
- R12: `cfg_we` loads ceiling, reset mode, gate and swap only while `en` is 0. A write made while `en` is 1 is ignored.
- R13: While `en` is 0, the count and `dir` hold and no status bit is set. After reset: count 0, `dir` 1, status 0, ceiling all ones, reset mode 1, gate 3, swap 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Counting enable; also locks the configuration |
| cfg_we | input | 1 | Load strobe for the configuration fields |
| cfg_swap | input | 1 | Exchange A and B before decoding |
| cfg_ceil_rst | input | 1 | 1: reset only at the ceiling; 0: qualified index also clears |
| cfg_gate | input | 2 | Index qualifying {A,B} level code |
| cfg_ceil | input | CNT_W | Ceiling (largest count value) |
| ph_a | input | 1 | Encoder phase A |
| ph_b | input | 1 | Encoder phase B |
| ph_idx | input | 1 | Encoder index |
| wdt_evt | input | 1 | Watchdog event from outside timing logic |
| irq_mask | input | 4 | Per-bit interrupt suppress |
| irq_clr | input | 4 | Write-1-to-clear for the status bits |
| count | output | CNT_W | Position count |
| dir | output | 1 | Last valid direction, 1 = up |
| irq_status | output | 4 | Sticky status: 0 watchdog, 1 reset down, 2 reset up, 3 direction change |
| irq | output | 1 | Interrupt request |

## Verification
The count, the direction and the status bits each change at the first rising edge after their pin, index, watchdog or clear input is present. The interrupt line follows the status with no added delay, and a configuration write takes effect at the edge that samples the strobe. The bench therefore drives every input just after a falling edge and samples all outputs at the next falling edge. A step-by-step arithmetic model advances at that same point, so each comparison falls exactly one rising edge after its stimulus. The sweeps cover every transition between pairs of phase levels with swap both off and on, every gate code against every level pair, and both reset modes.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    localparam int IRQ_N  = 4;
    localparam int ST_WDT = 0;
    localparam int ST_RDN = 1;
    localparam int ST_RUP = 2;
    localparam int ST_DIR = 3;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_e;
endpackage

// File: rtl/qdec_cfg.sv
module qdec_cfg #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic             swap_in,
    input  logic             ceil_rst_in,
    input  logic [1:0]       gate_in,
    input  logic [CNT_W-1:0] ceil_in,
    output logic             swap,
    output logic             ceil_rst,
    output logic [1:0]       gate,
    output logic [CNT_W-1:0] ceil
);
    typedef struct packed {
        logic             swap;
        logic             ceil_rst;
        logic [1:0]       gate;
        logic [CNT_W-1:0] ceil;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we && !en) begin
            cfg_d.swap     = swap_in;
            cfg_d.ceil_rst = ceil_rst_in;
            cfg_d.gate     = gate_in;
            cfg_d.ceil     = ceil_in;
        end
        swap     = cfg_q.swap;
        ceil_rst = cfg_q.ceil_rst;
        gate     = cfg_q.gate;
        ceil     = cfg_q.ceil;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.swap     <= 1'b0;
            cfg_q.ceil_rst <= 1'b1;
            cfg_q.gate     <= 2'b11;
            cfg_q.ceil     <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assert_cfg_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $stable(cfg_q));
endmodule

// File: rtl/qdec_step.sv
module qdec_step
    import qdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ph_a,
    input  logic       ph_b,
    input  logic       ph_idx,
    input  logic       swap,
    input  logic [1:0] gate,
    output step_e      step,
    output logic       idx_evt
);
    typedef struct packed {
        logic [1:0] ab;
        logic       qual;
    } pin_t;

    pin_t pin_d, pin_q;
    logic [1:0] cur_ab, cur_s, prev_s;
    logic       qual;

    always_comb begin
        cur_ab = {ph_a, ph_b};
        cur_s  = swap ? {ph_b, ph_a} : cur_ab;
        prev_s = swap ? {pin_q.ab[0], pin_q.ab[1]} : pin_q.ab;
        qual   = ph_idx && (cur_ab == gate);

        if (prev_s == cur_s) begin
            step = STEP_NONE;
        end else begin
            case ({prev_s, cur_s})
                4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: step = STEP_UP;
                4'b10_00, 4'b11_10, 4'b01_11, 4'b00_01: step = STEP_DOWN;
                default:                                step = STEP_BAD;
            endcase
        end

        idx_evt    = qual && !pin_q.qual;
        pin_d.ab   = cur_ab;
        pin_d.qual = qual;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= '0;
        end else begin
            pin_q <= pin_d;
        end
    end

    // R3: a change on both phases at once is never classified as a step
    assert_bad_is_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_q.ab[0] != ph_b) && (pin_q.ab[1] != ph_a) |-> (step == STEP_BAD));
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  step_e            step,
    input  logic             idx_evt,
    input  logic             ceil_rst,
    input  logic [CNT_W-1:0] ceil,
    output logic [CNT_W-1:0] count,
    output logic             dir,
    output logic [IRQ_N-1:0] ev
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
    } cnt_t;

    cnt_t c_d, c_q;
    logic take_idx;

    always_comb begin
        c_d      = c_q;
        ev       = '0;
        take_idx = idx_evt && !ceil_rst;
        if (en) begin
            if (take_idx) begin
                c_d.cnt    = '0;
                ev[ST_RUP] = c_q.dir;
                ev[ST_RDN] = !c_q.dir;
            end else begin
                case (step)
                    STEP_UP: begin
                        if (c_q.cnt == ceil) begin
                            c_d.cnt    = '0;
                            ev[ST_RUP] = 1'b1;
                        end else begin
                            c_d.cnt = c_q.cnt + 1'b1;
                        end
                        ev[ST_DIR] = !c_q.dir;
                        c_d.dir    = 1'b1;
                    end
                    STEP_DOWN: begin
                        if (c_q.cnt == '0) begin
                            c_d.cnt    = ceil;
                            ev[ST_RDN] = 1'b1;
                        end else begin
                            c_d.cnt = c_q.cnt - 1'b1;
                        end
                        ev[ST_DIR] = c_q.dir;
                        c_d.dir    = 1'b0;
                    end
                    default: ;
                endcase
            end
        end
        count = c_q.cnt;
        dir   = c_q.dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.cnt <= '0;
            c_q.dir <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assert_hold_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count) && $stable(dir));

    assert_illegal_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en && (step == STEP_BAD) && !(idx_evt && !ceil_rst) |=> $stable(count));

    assert_wrap_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        en && (step == STEP_UP) && (count == ceil) && !(idx_evt && !ceil_rst)
        |=> (count == '0));

    assert_wrap_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en && (step == STEP_DOWN) && (count == '0) && !(idx_evt && !ceil_rst)
        |=> (count == $past(ceil)));

    assert_index_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en && ceil_rst && (step == STEP_NONE) |=> $stable(count));
endmodule

// File: rtl/qdec_irq.sv
module qdec_irq
    import qdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             wdt,
    input  logic [IRQ_N-1:0] ev,
    input  logic [IRQ_N-1:0] clr,
    input  logic [IRQ_N-1:0] mask,
    output logic [IRQ_N-1:0] status,
    output logic             irq
);
    typedef struct packed {
        logic [IRQ_N-1:0] stat;
    } irq_t;

    irq_t i_d, i_q;
    logic [IRQ_N-1:0] set;

    always_comb begin
        set         = ev;
        set[ST_WDT] = set[ST_WDT] | wdt;
        if (!en) begin
            set = '0;
        end
        i_d.stat = (i_q.stat & ~clr) | set;
        status   = i_q.stat;
        irq      = |(i_q.stat & ~mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0;
        end else begin
            i_q <= i_d;
        end
    end

    assert_no_set_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((status & ~$past(status)) == '0));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~$past(clr) & ~status) == '0));

    assert_wdt_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en && wdt |=> status[ST_WDT]);
endmodule

// File: rtl/qdec_index_top.sv
module qdec_index_top
    import qdec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_we,
    input  logic             cfg_swap,
    input  logic             cfg_ceil_rst,
    input  logic [1:0]       cfg_gate,
    input  logic [CNT_W-1:0] cfg_ceil,
    input  logic             ph_a,
    input  logic             ph_b,
    input  logic             ph_idx,
    input  logic             wdt_evt,
    input  logic [IRQ_N-1:0] irq_mask,
    input  logic [IRQ_N-1:0] irq_clr,
    output logic [CNT_W-1:0] count,
    output logic             dir,
    output logic [IRQ_N-1:0] irq_status,
    output logic             irq
);
    logic             swap_w, ceil_rst_w, idx_evt_w;
    logic [1:0]       gate_w;
    logic [CNT_W-1:0] ceil_w;
    logic [IRQ_N-1:0] ev_w;
    step_e            step_w;

    qdec_cfg #(.CNT_W(CNT_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .en(en), .we(cfg_we),
        .swap_in(cfg_swap), .ceil_rst_in(cfg_ceil_rst),
        .gate_in(cfg_gate), .ceil_in(cfg_ceil),
        .swap(swap_w), .ceil_rst(ceil_rst_w), .gate(gate_w), .ceil(ceil_w)
    );

    qdec_step step_i (
        .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b), .ph_idx(ph_idx),
        .swap(swap_w), .gate(gate_w), .step(step_w), .idx_evt(idx_evt_w)
    );

    qdec_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .en(en), .step(step_w), .idx_evt(idx_evt_w),
        .ceil_rst(ceil_rst_w), .ceil(ceil_w),
        .count(count), .dir(dir), .ev(ev_w)
    );

    qdec_irq irq_i (
        .clk(clk), .rst_n(rst_n), .en(en), .wdt(wdt_evt), .ev(ev_w),
        .clr(irq_clr), .mask(irq_mask), .status(irq_status), .irq(irq)
    );
endmodule

// File: tb/qdec_index_top_tb_top.sv
`timescale 1ns/1ps
module qdec_index_top_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0, cfg_we = 1'b0, cfg_swap = 1'b0, cfg_ceil_rst = 1'b1;
    logic [1:0]   cfg_gate = 2'b11;
    logic [W-1:0] cfg_ceil = '1;
    logic         ph_a = 1'b0, ph_b = 1'b0, ph_idx = 1'b0, wdt_evt = 1'b0;
    logic [3:0]   irq_mask = 4'h0, irq_clr = 4'h0;
    logic [W-1:0] count;
    logic         dir;
    logic [3:0]   irq_status;
    logic         irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    logic [W-1:0] m_cnt = '0, m_ceil = '1;
    logic         m_dir = 1'b1, m_swap = 1'b0, m_mode = 1'b1, m_qual = 1'b0;
    logic [1:0]   m_gate = 2'b11, m_ab = 2'b00;
    logic [3:0]   m_stat = 4'h0;

    always #10 clk = ~clk;

    qdec_index_top #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we), .cfg_swap(cfg_swap),
        .cfg_ceil_rst(cfg_ceil_rst), .cfg_gate(cfg_gate), .cfg_ceil(cfg_ceil),
        .ph_a(ph_a), .ph_b(ph_b), .ph_idx(ph_idx), .wdt_evt(wdt_evt),
        .irq_mask(irq_mask), .irq_clr(irq_clr), .count(count), .dir(dir),
        .irq_status(irq_status), .irq(irq)
    );

    function automatic int gpos(input logic [1:0] ab);
        case (ab)
            2'b00: gpos = 0;
            2'b10: gpos = 1;
            2'b11: gpos = 2;
            default: gpos = 3;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "count", count, m_cnt);
        chk(tag, "dir", W'(dir), W'(m_dir));
        chk(tag, "status", W'(irq_status), W'(m_stat));
        chk(tag, "irq", W'(irq), W'(|(m_stat & ~irq_mask)));
    endtask

    // advance the model over the coming rising edge, then move to the next falling edge
    task automatic tick();
        logic [1:0] cur, cs, ps;
        logic       qual, rise;
        logic [3:0] set;
        int         d;
        cur  = {ph_a, ph_b};
        cs   = m_swap ? {cur[0], cur[1]} : cur;
        ps   = m_swap ? {m_ab[0], m_ab[1]} : m_ab;
        d    = (gpos(cs) - gpos(ps) + 4) % 4;
        qual = ph_idx && (cur == m_gate);
        rise = qual && !m_qual;
        set  = 4'h0;
        if (en) begin
            if (rise && !m_mode) begin
                m_cnt = '0;
                if (m_dir) set[2] = 1'b1; else set[1] = 1'b1;
            end else if (d == 1) begin
                if (m_cnt == m_ceil) begin m_cnt = '0; set[2] = 1'b1; end
                else m_cnt = m_cnt + 1;
                if (!m_dir) set[3] = 1'b1;
                m_dir = 1'b1;
            end else if (d == 3) begin
                if (m_cnt == 0) begin m_cnt = m_ceil; set[1] = 1'b1; end
                else m_cnt = m_cnt - 1;
                if (m_dir) set[3] = 1'b1;
                m_dir = 1'b0;
            end
            if (wdt_evt) set[0] = 1'b1;
        end
        m_stat = (m_stat & ~irq_clr) | set;
        if (cfg_we && !en) begin
            m_swap = cfg_swap; m_mode = cfg_ceil_rst; m_gate = cfg_gate; m_ceil = cfg_ceil;
        end
        m_ab   = cur;
        m_qual = qual;
        @(negedge clk);
    endtask

    task automatic set_pins(input logic [1:0] ab);
        ph_a = ab[1];
        ph_b = ab[0];
        tick();
    endtask

    task automatic reconfig(input logic sw, input logic mode, input logic [1:0] g,
                            input logic [W-1:0] c);
        en = 1'b0; tick();
        cfg_we = 1'b1; cfg_swap = sw; cfg_ceil_rst = mode; cfg_gate = g; cfg_ceil = c;
        tick();
        cfg_we = 1'b0; en = 1'b1; tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [1:0] seq [4];
        seq[0] = 2'b00; seq[1] = 2'b10; seq[2] = 2'b11; seq[3] = 2'b01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R13 reset");

        // small ceiling, then a write while enabled must be ignored
        reconfig(1'b0, 1'b1, 2'b11, 32'd5);
        cfg_we = 1'b1; cfg_ceil = 32'd100; cfg_swap = 1'b1; tick();
        cfg_we = 1'b0;
        chk_all("R12 write while enabled");
        for (int k = 0; k < 14; k++) begin
            set_pins(seq[(k + 1) % 4]);
            chk_all("R1 R4 R12 up wrap");
        end
        for (int k = 14; k > 0; k--) begin
            set_pins(seq[(k - 1) % 4]);
            chk_all("R1 R5 R8 down wrap");
        end

        // every pair of phase levels, swap off and on
        for (int s = 0; s < 2; s++) begin
            reconfig(s[0], 1'b1, 2'b11, 32'd5);
            for (int p = 0; p < 4; p++) begin
                for (int n = 0; n < 4; n++) begin
                    set_pins(p[1:0]);
                    chk_all(s == 0 ? "R1 R3 R8 sweep" : "R2 R3 R8 sweep");
                    set_pins(n[1:0]);
                    chk_all(s == 0 ? "R1 R3 R4 R5 sweep" : "R2 R3 R4 R5 sweep");
                end
            end
        end

        // sticky clear, set beats clear, watchdog
        irq_clr = 4'hF; tick(); irq_clr = 4'h0;
        chk_all("R10 clear all");
        wdt_evt = 1'b1; irq_clr = 4'h1; tick(); wdt_evt = 1'b0; irq_clr = 4'h0;
        chk_all("R9 R10 set beats clear");
        tick();
        chk_all("R10 sticky");
        irq_mask = 4'h1; #1;
        chk_all("R11 masked");
        irq_mask = 4'hE; #1;
        chk_all("R11 unmasked");
        irq_mask = 4'h0;

        // index gating sweep in index-reset mode
        reconfig(1'b0, 1'b0, 2'b00, 32'd40);
        for (int g = 0; g < 4; g++) begin
            reconfig(1'b0, 1'b0, g[1:0], 32'd40);
            for (int st = 0; st < 4; st++) begin
                for (int k = 0; k < 3; k++) set_pins(seq[(st + k + 1) % 4]);
                set_pins(st[1:0]);
                irq_clr = 4'hF; tick(); irq_clr = 4'h0;
                ph_idx = 1'b1; tick();
                chk_all("R6 gated index");
                ph_idx = 1'b0; tick();
                chk_all("R6 index low");
            end
        end

        // ceiling-reset mode ignores index
        reconfig(1'b0, 1'b1, 2'b00, 32'd40);
        set_pins(2'b10); set_pins(2'b11); set_pins(2'b01); set_pins(2'b00);
        ph_idx = 1'b1; tick();
        chk_all("R7 index ignored");
        ph_idx = 1'b0; tick();

        // disabled: no counting, no status
        irq_clr = 4'hF; tick(); irq_clr = 4'h0;
        en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            wdt_evt = 1'b1;
            set_pins(seq[(k + 1) % 4]);
            chk_all("R13 disabled hold");
        end
        wdt_evt = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule